// File: doc/BRIEF.md
# Multi-Mode Event Counter Channel

This block is one 16-bit counter channel for a timer subsystem. Each enabled clock cycle it looks at two event inputs that are already synchronised (a primary and a secondary), a pair of cascade strobes and a capture strobe. The selected count mode turns these into count steps up or down. The count mode picks one of eight behaviours: plain edge counting, counting both edges, gated counting, quadrature decoding, direction taken from the secondary input, a one-shot run started by a trigger, and cascaded counting driven by a neighbouring channel.

Two internal compare registers act as count targets. A step that would land on the active target is a compare hit. A hit can re-initialise the counter, halt it, flip the alternating target, or copy a compare-load value into either compare register. Sticky compare and overflow flags, a one-cycle compare strobe and a last-direction bit let surrounding output and interrupt logic follow the channel. Prescaling, input filtering, the register bus and interrupt routing belong to neighbouring blocks.

Top module: `mmt_counter_core`

## Requirements
- R1: After reset the count, flags, compare registers and direction bit are all zero. While `en` is low nothing moves. Mode code 000 never counts.
- R2: Mode 001 steps once per rising primary edge, or per falling edge when `edge_pol` is 1. When `pri_is_clk` is 1, every enabled cycle is a step, whatever the polarity. The direction is up when `cnt_down` is 0.
- R3: Mode 010 steps on both primary edges and does not count at all when `pri_is_clk` is 1. Mode 011 steps on rising primary edges only while `sec_in` is high.
- R4: Mode 100 decodes quadrature with (pri,sec) running 00→10→11→01→00 as up and the reverse as down. It takes one step per single-bit change, and a change of both bits gives no step.
- R5: Mode 101 counts primary edges (with the polarity rule of R2) up while `sec_in` is low and down while it is high. Mode 111 counts up on `casc_up` alone and down on `casc_dn` alone.
- R6: A step from 0xFFFF up or from 0x0000 down wraps the count and sets `ovf_flag`, unless the same step re-initialises the counter.
- R7: A step whose result equals the target is a hit. The target is compare 1 when counting up and compare 2 when counting down. A hit sets the matching flag and pulses `cmp_pulse` one cycle later. With `len_mode` set, the counter loads the re-initialisation value instead of the target.
- R8: With `alt_cmp` set and `len_mode` set, the target alternates between compare 1 and compare 2 after every hit, starting with compare 1 at `arm`.
- R9: With `once_mode` set, a hit halts counting until `arm`. With `alt_cmp` also set, the hit on compare 1 re-initialises the counter, and the hit on compare 2 halts it.
- R10: In mode 110 a rising secondary edge starts counting of primary rising edges. A further rising edge while running stops the count (`retrig`=0) or reloads it and keeps running (`retrig`=1). A hit reloads the counter and stops it.
- R11: A capture strobe with `reload_on_cap` set re-initialises the counter, and with it clear it has no effect. The re-initialisation value is `load_val`, or `cl2_val` when `alt_load` is set and the direction is down.
- R12: A compare register whose 2-bit preload code is 01 takes its compare-load value on a compare-1 hit. Code 10 does the same on a compare-2 hit. Codes 00 and 11 never preload.
- R13: The flags stay set until written with 1 through their clear inputs. A set and a clear in the same cycle leave the flag set.
- R14: `dir_up` holds the direction of the last step taken: 1 for up, 0 for down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| pri_in | input | 1 | Primary event level |
| sec_in | input | 1 | Secondary event level |
| pri_is_clk | input | 1 | Primary source is the undivided clock |
| casc_up | input | 1 | Cascade up strobe |
| casc_dn | input | 1 | Cascade down strobe |
| cap_evt | input | 1 | Capture strobe |
| arm | input | 1 | Load `load_val`, clear halt, phase and trigger state |
| mode_sel | input | 3 | Count mode code |
| cnt_down | input | 1 | Count direction for direction-fixed modes |
| len_mode | input | 1 | Re-initialise on hit |
| once_mode | input | 1 | Halt after hit |
| alt_cmp | input | 1 | Alternate compare targets |
| edge_pol | input | 1 | Count falling edges in modes 001/101 |
| retrig | input | 1 | Triggered mode: reload on second trigger |
| reload_on_cap | input | 1 | Capture strobe re-initialises |
| alt_load | input | 1 | Use `cl2_val` when re-initialising downward |
| pl1_sel | input | 2 | Preload code for compare 1 |
| pl2_sel | input | 2 | Preload code for compare 2 |
| load_val | input | 16 | Re-initialisation value |
| cl1_val | input | 16 | Compare-load value for compare 1 |
| cl2_val | input | 16 | Compare-load value for compare 2 and alternate load |
| cmp_wr | input | 2 | Write strobes, bit 0 compare 1, bit 1 compare 2 |
| cmp_wdata | input | 16 | Compare write data |
| clr_cmp1 | input | 1 | Clear compare 1 flag |
| clr_cmp2 | input | 1 | Clear compare 2 flag |
| clr_ovf | input | 1 | Clear overflow flag |
| count | output | 16 | Counter value |
| dir_up | output | 1 | Last step direction |
| cmp1_flag | output | 1 | Sticky compare 1 flag |
| cmp2_flag | output | 1 | Sticky compare 2 flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_pulse | output | 1 | One-cycle compare strobe |

## Verification
Two events can fall in the same cycle. A flag can be set by a hit in the cycle where software clears it: the bench drives the clear strobe together with the primary edge that produces the hit, and expects the flag to read 1 afterwards. A compare hit can also coincide with a wrap: counting up through 0xFFFF with compare 1 at zero must give a count of 1, with both the overflow flag and the compare-1 flag set. Separate runs cover the hit that re-initialises, where no overflow may be recorded.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [2:0] {
        M_IDLE   = 3'b000,
        M_RISE   = 3'b001,
        M_BOTH   = 3'b010,
        M_GATED  = 3'b011,
        M_QUAD   = 3'b100,
        M_DIRSEC = 3'b101,
        M_TRIG   = 3'b110,
        M_CASC   = 3'b111
    } cmode_e;

    typedef enum logic [1:0] {
        PL_NEVER = 2'b00,
        PL_ON_C1 = 2'b01,
        PL_ON_C2 = 2'b10,
        PL_RSVD  = 2'b11
    } pload_e;

    typedef struct packed {
        logic step;
        logic up;
    } step_t;

    typedef struct packed {
        logic cur_p;
        logic cur_s;
        logic old_p;
        logic old_s;
    } pins_t;

    // One step per single-bit Gray transition; both bits changing gives nothing.
    function automatic step_t quad_decode(input pins_t p);
        step_t r;
        r.step = 1'b0;
        r.up   = 1'b0;
        if ((p.old_p ^ p.cur_p) && !(p.old_s ^ p.cur_s)) begin
            r.step = 1'b1;
            r.up   = p.cur_p ^ p.cur_s;
        end else if (!(p.old_p ^ p.cur_p) && (p.old_s ^ p.cur_s)) begin
            r.step = 1'b1;
            r.up   = ~(p.cur_s ^ p.cur_p);
        end
        return r;
    endfunction

    function automatic logic preload_due(input pload_e c, input logic h1, input logic h2);
        return ((c == PL_ON_C1) && h1) || ((c == PL_ON_C2) && h2);
    endfunction

endpackage

// File: rtl/mmt_step_dec.sv
module mmt_step_dec
    import mmt_pkg::*;
(
    input  cmode_e mode,
    input  pins_t  pins,
    input  logic   pri_is_clk,
    input  logic   edge_pol,
    input  logic   cnt_down,
    input  logic   casc_up,
    input  logic   casc_dn,
    output step_t  st,
    output logic   trig_evt
);
    logic p_rise, p_fall, s_rise, p_plain, p_pol;

    always_comb begin
        p_rise  = pins.cur_p & ~pins.old_p;
        p_fall  = ~pins.cur_p & pins.old_p;
        s_rise  = pins.cur_s & ~pins.old_s;
        p_plain = pri_is_clk | p_rise;
        p_pol   = pri_is_clk | (edge_pol ? p_fall : p_rise);
        st.step = 1'b0;
        st.up   = ~cnt_down;
        unique case (mode)
            M_IDLE:   st.step = 1'b0;
            M_RISE:   st.step = p_pol;
            M_BOTH:   st.step = ~pri_is_clk & (p_rise | p_fall);
            M_GATED:  st.step = p_plain & pins.cur_s;
            M_QUAD:   st = quad_decode(pins);
            M_DIRSEC: begin
                st.step = p_pol;
                st.up   = ~pins.cur_s;
            end
            M_TRIG:   st.step = p_plain;
            M_CASC:   begin
                st.step = casc_up ^ casc_dn;
                st.up   = casc_up;
            end
            default:  st.step = 1'b0;
        endcase
        trig_evt = (mode == M_TRIG) & s_rise;
    end
endmodule

// File: rtl/mmt_cmp_bank.sv
module mmt_cmp_bank
    import mmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   wr,
    input  logic [W-1:0] wdata,
    input  logic [1:0]   pl1_sel,
    input  logic [1:0]   pl2_sel,
    input  logic [W-1:0] cl1_val,
    input  logic [W-1:0] cl2_val,
    input  logic         hit1,
    input  logic         hit2,
    output logic [W-1:0] cmp1,
    output logic [W-1:0] cmp2
);
    localparam int NCH = 2;

    logic [W-1:0] cmp_q [NCH];
    logic [W-1:0] cl    [NCH];
    pload_e       pl    [NCH];

    always_comb begin
        cl[0] = cl1_val;
        cl[1] = cl2_val;
        pl[0] = pload_e'(pl1_sel);
        pl[1] = pload_e'(pl2_sel);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rst)
                cmp_q[i] <= '0;
            else if (wr[i])
                cmp_q[i] <= wdata;
            else if (preload_due(pl[i], hit1, hit2))
                cmp_q[i] <= cl[i];
        end
    end

    assign cmp1 = cmp_q[0];
    assign cmp2 = cmp_q[1];
endmodule

// File: rtl/mmt_counter_core.sv
module mmt_counter_core
    import mmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         pri_in,
    input  logic         sec_in,
    input  logic         pri_is_clk,
    input  logic         casc_up,
    input  logic         casc_dn,
    input  logic         cap_evt,
    input  logic         arm,
    input  logic [2:0]   mode_sel,
    input  logic         cnt_down,
    input  logic         len_mode,
    input  logic         once_mode,
    input  logic         alt_cmp,
    input  logic         edge_pol,
    input  logic         retrig,
    input  logic         reload_on_cap,
    input  logic         alt_load,
    input  logic [1:0]   pl1_sel,
    input  logic [1:0]   pl2_sel,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cl1_val,
    input  logic [W-1:0] cl2_val,
    input  logic [1:0]   cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         clr_cmp1,
    input  logic         clr_cmp2,
    input  logic         clr_ovf,
    output logic [W-1:0] count,
    output logic         dir_up,
    output logic         cmp1_flag,
    output logic         cmp2_flag,
    output logic         ovf_flag,
    output logic         cmp_pulse
);
    cmode_e       mode;
    pins_t        pins;
    step_t        st;
    logic         pri_q, sec_q, trig_evt;
    logic [W-1:0] cmp1, cmp2, cnt_q, nxt, target;
    logic         dir_q, phase_q, halted_q, trig_q;
    logic         f1_q, f2_q, fo_q, pulse_q;
    logic         alt_on, use_c2, cap_rl, trig_rl, trig_stop, blocked, gate;
    logic         do_step, hit, hit1, hit2, reload_at_hit, stop_at_hit, wrap;

    function automatic logic [W-1:0] reinit_val(input logic up);
        return (alt_load && !up) ? cl2_val : load_val;
    endfunction

    assign mode = cmode_e'(mode_sel);
    assign pins = '{cur_p: pri_in, cur_s: sec_in, old_p: pri_q, old_s: sec_q};

    mmt_step_dec u_dec (
        .mode       (mode),
        .pins       (pins),
        .pri_is_clk (pri_is_clk),
        .edge_pol   (edge_pol),
        .cnt_down   (cnt_down),
        .casc_up    (casc_up),
        .casc_dn    (casc_dn),
        .st         (st),
        .trig_evt   (trig_evt)
    );

    mmt_cmp_bank #(.W(W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr      (cmp_wr),
        .wdata   (cmp_wdata),
        .pl1_sel (pl1_sel),
        .pl2_sel (pl2_sel),
        .cl1_val (cl1_val),
        .cl2_val (cl2_val),
        .hit1    (hit1),
        .hit2    (hit2),
        .cmp1    (cmp1),
        .cmp2    (cmp2)
    );

    always_comb begin
        alt_on    = alt_cmp & (len_mode | once_mode);
        use_c2    = alt_on ? phase_q : ~st.up;
        target    = use_c2 ? cmp2 : cmp1;
        nxt       = st.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        cap_rl    = cap_evt & reload_on_cap;
        trig_rl   = trig_evt & trig_q & retrig;
        trig_stop = trig_evt & trig_q & ~retrig;
        blocked   = arm | cap_rl | trig_rl | trig_stop;
        gate      = (mode != M_TRIG) | trig_q;
        do_step   = en & st.step & ~halted_q & ~blocked & gate;
        hit       = do_step & (nxt == target);
        hit1      = hit & ~use_c2;
        hit2      = hit & use_c2;
        reload_at_hit = len_mode | (mode == M_TRIG) | (alt_on & ~phase_q);
        stop_at_hit   = once_mode & ~(alt_on & ~phase_q);
        wrap      = do_step & (st.up ? (&cnt_q) : ~(|cnt_q)) & ~(hit & reload_at_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pri_q    <= 1'b0;
            sec_q    <= 1'b0;
            cnt_q    <= '0;
            dir_q    <= 1'b0;
            phase_q  <= 1'b0;
            halted_q <= 1'b0;
            trig_q   <= 1'b0;
            f1_q     <= 1'b0;
            f2_q     <= 1'b0;
            fo_q     <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pri_q   <= pri_in;
            sec_q   <= sec_in;
            pulse_q <= hit;
            f1_q    <= (f1_q & ~clr_cmp1) | hit1;
            f2_q    <= (f2_q & ~clr_cmp2) | hit2;
            fo_q    <= (fo_q & ~clr_ovf) | wrap;
            if (en) begin
                if (arm) begin
                    cnt_q    <= load_val;
                    phase_q  <= 1'b0;
                    halted_q <= 1'b0;
                    trig_q   <= 1'b0;
                end else if (cap_rl) begin
                    cnt_q <= reinit_val(dir_q);
                end else if (trig_rl) begin
                    cnt_q <= reinit_val(~cnt_down);
                end else if (trig_stop) begin
                    trig_q <= 1'b0;
                end else begin
                    if (trig_evt && !trig_q)
                        trig_q <= 1'b1;
                    if (do_step) begin
                        dir_q <= st.up;
                        if (hit) begin
                            cnt_q <= reload_at_hit ? reinit_val(st.up) : nxt;
                            if (alt_on)
                                phase_q <= ~phase_q;
                            if (stop_at_hit)
                                halted_q <= 1'b1;
                            if (mode == M_TRIG)
                                trig_q <= 1'b0;
                        end else begin
                            cnt_q <= nxt;
                        end
                    end
                end
            end
        end
    end

    assign count     = cnt_q;
    assign dir_up    = dir_q;
    assign cmp1_flag = f1_q;
    assign cmp2_flag = f2_q;
    assign ovf_flag  = fo_q;
    assign cmp_pulse = pulse_q;
endmodule

// File: rtl/mmt_counter_chk.sv
module mmt_counter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         arm,
    input logic         cap_evt,
    input logic         reload_on_cap,
    input logic [2:0]   mode_sel,
    input logic         len_mode,
    input logic         once_mode,
    input logic         clr_cmp1,
    input logic         clr_cmp2,
    input logic [W-1:0] count,
    input logic         cmp1_flag,
    input logic         cmp2_flag,
    input logic         ovf_flag,
    input logic         cmp_pulse
);
    // R1
    a_r1_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));

    // R1
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 3'b000 && !arm && !(cap_evt && reload_on_cap)) |=> $stable(count));

    // R4
    a_r4_quad_unit_step: assert property (@(posedge clk) disable iff (rst)
        (en && mode_sel == 3'b100 && !len_mode && !once_mode && !arm && !(cap_evt && reload_on_cap))
        |=> (count == $past(count) || count == $past(count) + 1'b1 || count == $past(count) - 1'b1));

    // R6
    a_r6_ovf_on_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> ((count == '0 && $past(count) == '1) ||
                             (count == '1 && $past(count) == '0)));

    // R7
    a_r7_pulse_with_flag: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |-> (cmp1_flag || cmp2_flag));

    // R13
    a_r13_sticky_c1: assert property (@(posedge clk) disable iff (rst)
        $fell(cmp1_flag) |-> $past(clr_cmp1));

    // R13
    a_r13_sticky_c2: assert property (@(posedge clk) disable iff (rst)
        $fell(cmp2_flag) |-> $past(clr_cmp2));
endmodule

bind mmt_counter_core mmt_counter_chk #(.W(W)) u_chk (.*);

// File: tb/mmt_counter_core_tb_top.sv
`timescale 1ns/1ps
module mmt_counter_core_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en, pri_in, sec_in, pri_is_clk, casc_up, casc_dn, cap_evt, arm;
    logic [2:0] mode_sel;
    logic cnt_down, len_mode, once_mode, alt_cmp, edge_pol, retrig, reload_on_cap, alt_load;
    logic [1:0] pl1_sel, pl2_sel, cmp_wr;
    logic [15:0] load_val, cl1_val, cl2_val, cmp_wdata, count;
    logic clr_cmp1, clr_cmp2, clr_ovf;
    logic dir_up, cmp1_flag, cmp2_flag, ovf_flag, cmp_pulse;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mmt_counter_core dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pri_in = 1'b1; tick();
            pri_in = 1'b0; tick();
        end
    endtask

    task automatic do_arm(input logic [15:0] v);
        load_val = v; arm = 1'b1; tick(); arm = 1'b0;
    endtask

    task automatic wcmp(input bit second, input logic [15:0] v);
        cmp_wdata = v; cmp_wr = second ? 2'b10 : 2'b01; tick(); cmp_wr = 2'b00;
    endtask

    task automatic clr_all();
        clr_cmp1 = 1'b1; clr_cmp2 = 1'b1; clr_ovf = 1'b1; tick();
        clr_cmp1 = 1'b0; clr_cmp2 = 1'b0; clr_ovf = 1'b0;
    endtask

    task automatic cfg_default();
        mode_sel = 3'b000; cnt_down = 0; len_mode = 0; once_mode = 0; alt_cmp = 0;
        edge_pol = 0; retrig = 0; reload_on_cap = 0; alt_load = 0; pri_is_clk = 0;
        pl1_sel = 2'b00; pl2_sel = 2'b00;
    endtask

    task automatic qset(input logic a, input logic b);
        pri_in = a; sec_in = b; tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        en = 1; pri_in = 0; sec_in = 0; casc_up = 0; casc_dn = 0; cap_evt = 0; arm = 0;
        load_val = 0; cl1_val = 0; cl2_val = 0; cmp_wr = 0; cmp_wdata = 0;
        clr_cmp1 = 0; clr_cmp2 = 0; clr_ovf = 0;
        cfg_default();
        tick(3); rst = 1'b0; tick();
        // R1 reset state
        chk("R1 reset count", count, 0);
        chk("R1 reset flags", {cmp1_flag, cmp2_flag, ovf_flag, dir_up}, 0);
        // R1 idle mode and disabled channel
        pulses(5); chk("R1 idle mode", count, 0);
        mode_sel = 3'b001; en = 0; pulses(4); chk("R1 disabled", count, 0); en = 1;

        // R2 sweep of rising edges, both directions
        for (int n = 0; n <= 12; n++) begin
            do_arm(0); pulses(n); chk("R2 up sweep", count, n);
        end
        chk("R14 dir after up", dir_up, 1);
        cnt_down = 1;
        for (int n = 1; n <= 12; n++) begin
            do_arm(100); pulses(n); chk("R2 down sweep", count, 100 - n);
        end
        chk("R14 dir after down", dir_up, 0);
        cnt_down = 0; edge_pol = 1; do_arm(0);
        pri_in = 1; tick(); chk("R2 rise ignored with pol", count, 0);
        pri_in = 0; tick(); chk("R2 fall counted", count, 1);
        pri_is_clk = 1; do_arm(0); tick(7); pri_is_clk = 0;
        chk("R2 clock source", count, 7);
        cfg_default();

        // R3 both edges and gated
        mode_sel = 3'b010;
        for (int n = 1; n <= 6; n++) begin
            do_arm(0); pulses(n); chk("R3 both edges", count, 2 * n);
        end
        pri_is_clk = 1; do_arm(0); tick(5); pri_is_clk = 0;
        chk("R3 both edges clock source", count, 0);
        mode_sel = 3'b011; do_arm(0); sec_in = 0; pulses(3);
        chk("R3 gated low", count, 0);
        sec_in = 1; pulses(4); chk("R3 gated high", count, 4); sec_in = 0; tick();

        // R4 quadrature
        mode_sel = 3'b100; do_arm(0);
        for (int r = 0; r < 2; r++) begin
            qset(1, 0); qset(1, 1); qset(0, 1); qset(0, 0);
        end
        chk("R4 forward", count, 8); chk("R14 quad up", dir_up, 1);
        qset(0, 1); qset(1, 1); qset(1, 0); qset(0, 0);
        chk("R4 reverse", count, 4); chk("R14 quad down", dir_up, 0);
        qset(1, 1); qset(0, 0); chk("R4 double change", count, 4);

        // R5 direction by secondary, cascade
        mode_sel = 3'b101; do_arm(0); pulses(5); chk("R5 sec low up", count, 5);
        sec_in = 1; tick(); pulses(2); chk("R5 sec high down", count, 3);
        sec_in = 0; tick();
        mode_sel = 3'b111; do_arm(10);
        casc_up = 1; tick(3); casc_up = 0; chk("R5 cascade up", count, 13);
        casc_dn = 1; tick(); casc_dn = 0; chk("R5 cascade down", count, 12);
        casc_up = 1; casc_dn = 1; tick(); casc_up = 0; casc_dn = 0;
        chk("R5 cascade both", count, 12);
        cfg_default();

        // R6 wrap with compare hit in the same step
        mode_sel = 3'b001; wcmp(0, 16'h0000); wcmp(1, 16'h0200); clr_all();
        do_arm(16'hFFFE); pulses(3);
        chk("R6 up wrap", count, 1);
        chk("R6 ovf and cmp1 same step", {ovf_flag, cmp1_flag}, 2'b11);
        clr_all(); chk("R13 clear", {ovf_flag, cmp1_flag}, 0);
        cnt_down = 1; do_arm(1); pulses(2);
        chk("R6 down wrap", count, 16'hFFFF); chk("R6 down ovf", ovf_flag, 1);
        cfg_default(); clr_all();

        // R11 reload on capture and alternate load
        mode_sel = 3'b001; wcmp(0, 16'h0100);
        do_arm(9); pulses(3);
        cap_evt = 1; tick(); cap_evt = 0; chk("R11 capture ignored", count, 12);
        reload_on_cap = 1; cap_evt = 1; tick(); cap_evt = 0; chk("R11 capture reload", count, 9);
        alt_load = 1; cnt_down = 1; cl2_val = 40; pulses(2); chk("R11 down before", count, 7);
        cap_evt = 1; tick(); cap_evt = 0; chk("R11 alternate load", count, 40);
        cfg_default(); clr_all();

        // R7 length mode, compare targets, strobe
        mode_sel = 3'b001; len_mode = 1; wcmp(0, 5); do_arm(2);
        pulses(2); chk("R7 before hit", count, 4); chk("R7 no flag yet", cmp1_flag, 0);
        pri_in = 1; tick();
        chk("R7 reinit", count, 2); chk("R7 strobe", cmp_pulse, 1); chk("R7 flag1", cmp1_flag, 1);
        pri_in = 0; tick(); chk("R7 strobe one cycle", cmp_pulse, 0);
        cnt_down = 1; wcmp(1, 10); do_arm(14); pulses(4);
        chk("R7 down reinit", count, 14); chk("R7 flag2", cmp2_flag, 1);
        cfg_default(); clr_all();

        // R13 set and clear in the same cycle
        mode_sel = 3'b001; len_mode = 1; wcmp(0, 2); do_arm(0); pulses(1);
        pri_in = 1; clr_cmp1 = 1; tick(); clr_cmp1 = 0; pri_in = 0; tick();
        chk("R13 set wins", cmp1_flag, 1);
        clr_cmp1 = 1; tick(); clr_cmp1 = 0; chk("R13 w1c", cmp1_flag, 0);

        // R8 alternating targets
        alt_cmp = 1; wcmp(0, 3); wcmp(1, 2); do_arm(0);
        pulses(2); chk("R8 phase0 mid", count, 2);
        pulses(1); chk("R8 hit cmp1", count, 0); chk("R8 flag1", cmp1_flag, 1);
        pulses(1); chk("R8 phase1 mid", count, 1);
        pulses(1); chk("R8 hit cmp2", count, 0); chk("R8 flag2", cmp2_flag, 1);
        pulses(2); chk("R8 back to cmp1", count, 2);
        cfg_default(); clr_all();

        // R9 once
        mode_sel = 3'b001; once_mode = 1; wcmp(0, 4); do_arm(0);
        pulses(6); chk("R9 halt at target", count, 4);
        alt_cmp = 1; wcmp(0, 3); wcmp(1, 2); do_arm(0);
        pulses(3); chk("R9 alt reinit at cmp1", count, 0);
        pulses(5); chk("R9 alt halt at cmp2", count, 2);
        cfg_default(); clr_all();

        // R12 preload
        mode_sel = 3'b001; len_mode = 1; pl1_sel = 2'b01; cl1_val = 4;
        wcmp(0, 2); do_arm(0); pulses(2); chk("R12 first period", count, 0);
        pulses(3); chk("R12 preloaded target", count, 3);
        pl1_sel = 2'b11; wcmp(0, 2); do_arm(0); pulses(2); pulses(3);
        chk("R12 reserved code", count, 1);
        cfg_default(); clr_all();

        // R10 triggered counting
        mode_sel = 3'b110; wcmp(0, 10); do_arm(0);
        pulses(2); chk("R10 idle before trigger", count, 0);
        sec_in = 1; tick(); sec_in = 0; pulses(3); chk("R10 running", count, 3);
        sec_in = 1; tick(); sec_in = 0; pulses(2); chk("R10 second trigger stops", count, 3);
        retrig = 1; do_arm(0);
        sec_in = 1; tick(); sec_in = 0; pulses(3);
        sec_in = 1; tick(); sec_in = 0; pulses(2); chk("R10 retrigger reload", count, 2);
        pulses(10); chk("R10 stop at compare", count, 0);
        cfg_default();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule